// File: doc/BRIEF.md
# Masked-Write Pin Bank Controller

This block sits between a simple register-write port and four 16-pin groups of bidirectional pad signals. Each group has two registers: a direction register, which decides whether each pin is driven by the block, and a level register, which holds the level the block drives. A register write uses the upper half of the 32-bit data word to choose which bits change, and the lower half to give their new values. Software can therefore flip one pin without first reading the register back.

A separate per-group override register hands any group over to an internal debug bus. While a group's override bit is set, both the direction and the level of its pins come from that bus. The registers keep their contents and take effect again when the bit is cleared. The levels seen on the pads are passed through a two-stage synchroniser and appear on a 64-bit readback output. The pad cells themselves are outside the block: it drives separate level, enable and input vectors.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every direction bit and every level bit is 0, and all override bits are 0. With debug inputs nonzero, padOe and padOut therefore both read 0.
- R2: A write with wrEn high to address 5+k (k = 0..3) updates direction register k at each bit i where wrData[16+i] is 1, setting it to wrData[i]. All other bits keep their value.
- R3: A write to address 9+k (k = 0..3) updates level register k with the same per-bit mask rule as R2.
- R4: While group k is not overridden, padOe[16k+15:16k] equals direction register k (1 = driven output, 0 = input) and padOut[16k+15:16k] equals level register k.
- R5: A write to address 14 loads wrData[3:0] into the override register, with bit k belonging to group k; this write has no mask. While override bit k is 1, the slices of padOut and padOe for group k follow dbgVal and dbgOe.
- R6: A write to any address other than 5..12 and 14 changes no register, so padOut and padOe are unchanged.
- R7: A write to addresses 5..12 whose wrData[31:16] is all zeros leaves the addressed register unchanged.
- R8: pinLevel equals the padIn value that was present two rising clock edges earlier.
- R9: While wrEn is low, no register changes, whatever wrAddr and wrData hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register address |
| wrData | input | 32 | Write data: mask in 31:16, values in 15:0 |
| dbgVal | input | 64 | Debug bus pin levels, 16 bits per group |
| dbgOe | input | 64 | Debug bus pin enables, 16 bits per group |
| padIn | input | 64 | Levels seen at the pads |
| padOut | output | 64 | Levels driven to the pads |
| padOe | output | 64 | Per-pin drive enable to the pads |
| pinLevel | output | 64 | Synchronised pad input levels |

## Verification
A write sampled at a rising edge updates its register at that same edge. padOut and padOe are combinational from the registers and the debug bus, so the new value is visible straight after that edge. pinLevel trails padIn by exactly two edges. The bench drives every input at the falling edge. At the next falling edge, before it drives anything new, it compares padOut and padOe with a model that has been advanced by the write just made. It compares pinLevel with the padIn value driven two falling edges before.

// File: rtl/gpioPkg.sv
package gpioPkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 16;
  localparam int PINS      = NUM_BANKS * BANK_W;

  typedef struct packed {
    logic [NUM_BANKS-1:0] oeWe;
    logic [NUM_BANKS-1:0] valWe;
    logic                 dbgWe;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpioPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int OE_BASE  = 5,
  parameter int VAL_BASE = 9,
  parameter int DBG_ADDR = 14
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strb
);
  // One address comparator per register, gated by the write strobe.
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] OeAddr  = ADDR_W'(OE_BASE + k);
    localparam logic [ADDR_W-1:0] ValAddr = ADDR_W'(VAL_BASE + k);
    assign strb.oeWe[k]  = wrEn && (wrAddr == OeAddr);
    assign strb.valWe[k] = wrEn && (wrAddr == ValAddr);
  end

  localparam logic [ADDR_W-1:0] DbgAddr = ADDR_W'(DBG_ADDR);
  assign strb.dbgWe = wrEn && (wrAddr == DbgAddr);
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpioPkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  wrStrobe_t            strb,
  input  logic [31:0]          wrData,
  input  logic [PINS-1:0]      dbgVal,
  input  logic [PINS-1:0]      dbgOe,
  input  logic [PINS-1:0]      padIn,
  output logic [PINS-1:0]      padOut,
  output logic [PINS-1:0]      padOe,
  output logic [PINS-1:0]      pinLevel,
  output logic [PINS-1:0]      oeQ,
  output logic [PINS-1:0]      valQ,
  output logic [NUM_BANKS-1:0] dbgEnQ
);
  logic [BANK_W-1:0] selMask;
  logic [BANK_W-1:0] newBits;

  assign selMask = wrData[2*BANK_W-1:BANK_W];
  assign newBits = wrData[BANK_W-1:0];

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [BANK_W-1:0] oeNext;
    logic [BANK_W-1:0] valNext;

    // Keep bits whose mask bit is 0, take the new bits where it is 1.
    assign oeNext  = (oeQ[k*BANK_W +: BANK_W]  & ~selMask) | (newBits & selMask);
    assign valNext = (valQ[k*BANK_W +: BANK_W] & ~selMask) | (newBits & selMask);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        oeQ[k*BANK_W +: BANK_W]  <= '0;
        valQ[k*BANK_W +: BANK_W] <= '0;
      end else begin
        if (strb.oeWe[k])  oeQ[k*BANK_W +: BANK_W]  <= oeNext;
        if (strb.valWe[k]) valQ[k*BANK_W +: BANK_W] <= valNext;
      end
    end

    // The override hands the whole group to the debug bus.
    always_comb begin
      if (dbgEnQ[k]) begin
        padOut[k*BANK_W +: BANK_W] = dbgVal[k*BANK_W +: BANK_W];
        padOe[k*BANK_W +: BANK_W]  = dbgOe[k*BANK_W +: BANK_W];
      end else begin
        padOut[k*BANK_W +: BANK_W] = valQ[k*BANK_W +: BANK_W];
        padOe[k*BANK_W +: BANK_W]  = oeQ[k*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          dbgEnQ <= '0;
    else if (strb.dbgWe) dbgEnQ <= wrData[NUM_BANKS-1:0];
  end

  gpio_sync2 #(.WIDTH(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (padIn),
    .dout  (pinLevel)
  );
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpioPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [PINS-1:0]   dbgVal,
  input  logic [PINS-1:0]   dbgOe,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   pinLevel
);
  wrStrobe_t            strb;
  logic [PINS-1:0]      oeQ;
  logic [PINS-1:0]      valQ;
  logic [NUM_BANKS-1:0] dbgEnQ;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strb   (strb)
  );

  gpio_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .dbgVal   (dbgVal),
    .dbgOe    (dbgOe),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .pinLevel (pinLevel),
    .oeQ      (oeQ),
    .valQ     (valQ),
    .dbgEnQ   (dbgEnQ)
  );
endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk
  import gpioPkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrEn,
  input logic [6:0]           wrAddr,
  input logic [31:0]          wrData,
  input logic [PINS-1:0]      dbgVal,
  input logic [PINS-1:0]      dbgOe,
  input logic [PINS-1:0]      padIn,
  input logic [PINS-1:0]      padOut,
  input logic [PINS-1:0]      padOe,
  input logic [PINS-1:0]      pinLevel,
  input logic [PINS-1:0]      oeQ,
  input logic [PINS-1:0]      valQ,
  input logic [NUM_BANKS-1:0] dbgEnQ
);
  logic [1:0] upCnt;
  logic       decoded;

  always_ff @(posedge clk) begin
    if (!rst_n)            upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assign decoded = (wrAddr >= 7'd5 && wrAddr <= 7'd12) || (wrAddr == 7'd14);

  // R6
  undecoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !decoded) |=> ($stable(oeQ) && $stable(valQ) && $stable(dbgEnQ)));

  // R9
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> ($stable(oeQ) && $stable(valQ) && $stable(dbgEnQ)));

  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr >= 7'd5 && wrAddr <= 7'd12 && wrData[31:16] == 16'h0)
      |=> ($stable(oeQ) && $stable(valQ)));

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3) |-> (pinLevel == $past(padIn, 2)));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    // R4
    reg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbgEnQ[k] |-> (padOe[k*BANK_W +: BANK_W] == oeQ[k*BANK_W +: BANK_W] &&
                      padOut[k*BANK_W +: BANK_W] == valQ[k*BANK_W +: BANK_W]));
    // R5
    dbg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbgEnQ[k] |-> (padOe[k*BANK_W +: BANK_W] == dbgOe[k*BANK_W +: BANK_W] &&
                     padOut[k*BANK_W +: BANK_W] == dbgVal[k*BANK_W +: BANK_W]));
  end
endmodule

bind gpio_pin_bank gpio_pin_bank_chk u_chk (.*);

// File: tb/sim_gpio_pin_bank.sv
`timescale 1ns/1ps
module sim_gpio_pin_bank;
  import gpioPkg::*;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wrEn;
  logic [6:0]      wrAddr;
  logic [31:0]     wrData;
  logic [PINS-1:0] dbgVal, dbgOe, padIn;
  logic [PINS-1:0] padOut, padOe, pinLevel;

  int nRun = 0;
  int nFail = 0;
  logic [PINS-1:0]      mOe, mVal;
  logic [NUM_BANKS-1:0] mDbg;
  logic [PINS-1:0]      inCur, inPrev;

  always #2 clk = ~clk;

  gpio_pin_bank u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgVal(dbgVal), .dbgOe(dbgOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pinLevel(pinLevel)
  );

  function automatic logic [PINS-1:0] expPads(logic [PINS-1:0] regs, logic [PINS-1:0] bus);
    logic [PINS-1:0] r;
    for (int k = 0; k < NUM_BANKS; k++)
      r[k*BANK_W +: BANK_W] = mDbg[k] ? bus[k*BANK_W +: BANK_W] : regs[k*BANK_W +: BANK_W];
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] merge(logic [BANK_W-1:0] old, logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  task automatic check(string tag, string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Check the results of the previous cycle, then drive the next one.
  task automatic cycle(string tag, logic en, logic [6:0] a, logic [31:0] d,
                       logic [PINS-1:0] dv, logic [PINS-1:0] dO, logic [PINS-1:0] pin);
    @(negedge clk);
    check(tag, "padOe",    padOe,    expPads(mOe, dbgOe));
    check(tag, "padOut",   padOut,   expPads(mVal, dbgVal));
    check("R8", "pinLevel", pinLevel, inPrev);
    wrEn = en; wrAddr = a; wrData = d; dbgVal = dv; dbgOe = dO; padIn = pin;
    inPrev = inCur; inCur = pin;
    if (en) begin
      if (a >= 7'd5 && a <= 7'd8)
        mOe[(a-7'd5)*BANK_W +: BANK_W] = merge(mOe[(a-7'd5)*BANK_W +: BANK_W], d);
      else if (a >= 7'd9 && a <= 7'd12)
        mVal[(a-7'd9)*BANK_W +: BANK_W] = merge(mVal[(a-7'd9)*BANK_W +: BANK_W], d);
      else if (a == 7'd14)
        mDbg = d[3:0];
    end
  endtask

  task automatic idle(string tag);
    cycle(tag, 1'b0, 7'd0, 32'h0, dbgVal, dbgOe, padIn);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [PINS-1:0] r64a, r64b, r64c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    dbgVal = {4{16'hA5C3}}; dbgOe = {4{16'hFFFF}}; padIn = '0;
    mOe = '0; mVal = '0; mDbg = '0; inCur = '0; inPrev = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state with debug inputs nonzero
    idle("R1");
    idle("R1");

    // R2: partial mask on direction register of group 0
    cycle("R2", 1'b1, 7'd5, 32'h00FF_AAAA, dbgVal, dbgOe, padIn);
    idle("R2");
    cycle("R2", 1'b1, 7'd8, 32'hF00F_1234, dbgVal, dbgOe, padIn);
    idle("R2");
    // R3: level registers, masked
    cycle("R3", 1'b1, 7'd9, 32'hFFFF_BEEF, dbgVal, dbgOe, padIn);
    cycle("R3", 1'b1, 7'd9, 32'h0101_0000, dbgVal, dbgOe, padIn);
    cycle("R3", 1'b1, 7'd12, 32'h8001_FFFF, dbgVal, dbgOe, padIn);
    idle("R3 R4");
    // R7: zero mask leaves register unchanged
    cycle("R7", 1'b1, 7'd9, 32'h0000_FFFF, dbgVal, dbgOe, padIn);
    cycle("R7", 1'b1, 7'd5, 32'h0000_5555, dbgVal, dbgOe, padIn);
    idle("R7");
    // R6: undecoded addresses 13, 4, 15, 127
    cycle("R6", 1'b1, 7'd13, 32'hFFFF_FFFF, dbgVal, dbgOe, padIn);
    cycle("R6", 1'b1, 7'd4, 32'hFFFF_FFFF, dbgVal, dbgOe, padIn);
    cycle("R6", 1'b1, 7'd15, 32'hFFFF_FFFF, dbgVal, dbgOe, padIn);
    cycle("R6", 1'b1, 7'd127, 32'hFFFF_FFFF, dbgVal, dbgOe, padIn);
    idle("R6");
    // R9: strobe low with a decoded address
    cycle("R9", 1'b0, 7'd6, 32'hFFFF_FFFF, dbgVal, dbgOe, padIn);
    cycle("R9", 1'b0, 7'd14, 32'h0000_000F, dbgVal, dbgOe, padIn);
    idle("R9");
    // R5: override groups 1 and 3, then release
    cycle("R5", 1'b1, 7'd14, 32'hFFFF_000A, 64'h1111_2222_3333_4444,
          64'hF0F0_0F0F_FF00_00FF, padIn);
    idle("R5");
    cycle("R5", 1'b0, 7'd0, 32'h0, 64'h9999_8888_7777_6666, 64'h0, padIn);
    cycle("R5", 1'b1, 7'd14, 32'h0000_0000, dbgVal, dbgOe, padIn);
    idle("R5");
    // R8: walking input patterns
    cycle("R8", 1'b0, 7'd0, 32'h0, dbgVal, dbgOe, 64'hFFFF_FFFF_FFFF_FFFF);
    cycle("R8", 1'b0, 7'd0, 32'h0, dbgVal, dbgOe, 64'h0123_4567_89AB_CDEF);
    cycle("R8", 1'b0, 7'd0, 32'h0, dbgVal, dbgOe, 64'h0);
    idle("R8");

    // Constrained random: addresses 0..15, mixed masks and strobes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [6:0]  a;
      a = 7'($urandom_range(0, 15));
      d = $urandom;
      if ($urandom_range(0, 7) == 0) d[31:16] = 16'h0;
      r64a = {$urandom, $urandom};
      r64b = {$urandom, $urandom};
      r64c = {$urandom, $urandom};
      cycle("R2 R3 R4 R5", ($urandom_range(0, 3) != 0), a, d, r64a, r64b, r64c);
    end
    idle("R4");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule